// File: doc/BRIEF.md
# Latency-Balanced Dual-Path Select Pipeline

This block is a fully pipelined datapath for a loop whose body chooses between two data sources with a branch. It does not branch in hardware. Every accepted item passes down a long source path and a short source path at the same time. Padding registers stretch the short path so that both results reach a final multiplexer on the same clock edge. The multiplexer keeps the result of the chosen path. An increment stage adds one to it, and a write port presents the value together with its loop index.

The branch condition comes from a select argument. It is captured when a run starts and holds for the whole run: zero picks the long-path source, and any other value picks the short-path source. A run handles a fixed number of iterations, 20 by default. Each source input is a valid/ready stream, and the pipeline accepts one item per cycle. An item enters only when both sources offer data in the same cycle. Backpressure on the write port freezes every stage, padding stages included. A controller steps through the states IDLE, ISSUE, DRAIN and DONE. IDLE goes to ISSUE on `start`. ISSUE goes to DRAIN when the last iteration is accepted. DRAIN goes to DONE when the last write is accepted. DONE returns to IDLE after one cycle.

Top module: `dpp_dual_path`

## Requirements
- R1: While reset is applied and in the first cycles after it, `wr_valid`, `done`, `busy`, `src_a_ready` and `src_b_ready` are all 0.
- R2: A `start` pulse in IDLE captures `sel_in`. A value of zero selects source A, and any nonzero value selects source B. Changes to `sel_in` during a run have no effect on the written data.
- R3: Every written value equals the selected source's data for that iteration plus one, modulo 2^32. For example, 0xFFFFFFFF is written as 0x00000000.
- R4: Without backpressure, an item accepted in cycle c is presented on the write port in cycle c+6. This holds for either select value. With backpressure, the delay is never less than 6.
- R5: A run accepts exactly 20 items. Once 20 items have been accepted, both source readies stay 0 until the next run.
- R6: `wr_idx` counts 0 to 19 in order and advances only when a write is accepted (`wr_valid` and `wr_ready` both 1).
- R7: An item is taken from the sources only when both are valid in the same cycle. A source's ready is 0 whenever the other source is not valid, and both handshakes always complete together.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, the whole pipeline holds. The write port keeps the same index and data, and no item is lost, duplicated or reordered.
- R9: `done` is 1 for exactly one cycle, the cycle after the 20th write is accepted. `busy` is 0 from then on.
- R10: A `start` pulse that arrives while a run is active is ignored. The run keeps its select value, its index and its item count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when IDLE |
| sel_in | input | 8 | Branch select, captured at start |
| src_a_valid | input | 1 | Source A (long path) has data |
| src_a_ready | output | 1 | Source A item taken |
| src_a_data | input | 32 | Source A data |
| src_b_valid | input | 1 | Source B (short path) has data |
| src_b_ready | output | 1 | Source B item taken |
| src_b_data | input | 32 | Source B data |
| wr_valid | output | 1 | Write port holds a result |
| wr_ready | input | 1 | Consumer takes the write |
| wr_idx | output | 5 | Iteration index of the write |
| wr_data | output | 32 | Incremented selected value |
| done | output | 1 | One-cycle end-of-run pulse |
| busy | output | 1 | Run in ISSUE or DRAIN |

## Verification
A padding register that is missing or extra shows up on the very first write of a run. The item appears on the write port one cycle early or late for one of the two select values. A stage that ignores the stall shows up on the next write under backpressure, as changed data or a skipped or repeated index. A wrong iteration count or a wrong state transition shows up at the end of the run, as a wrong number of writes or a `done` pulse in the wrong cycle. The bench sweeps all select classes against several valid and backpressure patterns, so each of these faults is seen within one run.

// File: rtl/dpp_pkg.sv
`timescale 1ns/1ps
package dpp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } dpp_state_e;
endpackage

// File: rtl/dpp_delay_line.sv
`timescale 1ns/1ps
// Enable-gated shift register of DEPTH stages (DEPTH >= 1).
module dpp_delay_line #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else if (en) begin
            stg[0] <= din;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/dpp_ctrl.sv
`timescale 1ns/1ps
// Run controller: issue counting, write indexing, end-of-run pulse.
module dpp_ctrl
    import dpp_pkg::*;
#(
    parameter int ITER = 20,
    localparam int IW = (ITER > 1) ? $clog2(ITER) : 1,
    localparam int CW = $clog2(ITER + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          in_fire,
    input  logic          out_fire,
    output logic          issue_open,
    output logic          load_sel,
    output logic          busy,
    output logic          done,
    output logic [IW-1:0] wr_idx
);
    dpp_state_e    state_q, state_d;
    logic [CW-1:0] issued_q;
    logic [IW-1:0] wcnt_q;

    wire last_in  = in_fire  && (issued_q == CW'(ITER - 1));
    wire last_out = out_fire && (wcnt_q   == IW'(ITER - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_d = ST_ISSUE;
            ST_ISSUE: if (last_in)  state_d = ST_DRAIN;
            ST_DRAIN: if (last_out) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            issued_q <= '0;
            wcnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                issued_q <= '0;
                wcnt_q   <= '0;
            end else begin
                if (in_fire)  issued_q <= issued_q + CW'(1);
                if (out_fire) wcnt_q   <= last_out ? '0 : wcnt_q + IW'(1);
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        issue_open = 1'b0;
        busy       = 1'b0;
        done       = 1'b0;
        load_sel   = 1'b0;
        unique case (state_q)
            ST_IDLE:  load_sel = start;
            ST_ISSUE: begin issue_open = 1'b1; busy = 1'b1; end
            ST_DRAIN: busy = 1'b1;
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    assign wr_idx = wcnt_q;

    AST_ISSUE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        issued_q <= CW'(ITER)); // R5
    AST_DRAIN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> (issued_q == CW'(ITER))); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_NO_FIRE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |-> (state_q == ST_ISSUE)); // R10
endmodule

// File: rtl/dpp_dual_path.sv
`timescale 1ns/1ps
// Both source paths run every cycle; the shorter is padded to equal latency.
module dpp_dual_path #(
    parameter int DATA_W  = 32,
    parameter int SEL_W   = 8,
    parameter int ITER    = 20,
    parameter int LAT_A   = 5,
    parameter int LAT_B   = 3,
    parameter int INC_LAT = 1,
    localparam int IW = (ITER > 1) ? $clog2(ITER) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              src_a_valid,
    output logic              src_a_ready,
    input  logic [DATA_W-1:0] src_a_data,
    input  logic              src_b_valid,
    output logic              src_b_ready,
    input  logic [DATA_W-1:0] src_b_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [IW-1:0]     wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic              busy
);
    localparam int LAT_MAX = (LAT_A > LAT_B) ? LAT_A : LAT_B;
    localparam int PAD_A   = LAT_MAX - LAT_A;
    localparam int PAD_B   = LAT_MAX - LAT_B;

    logic              issue_open, load_sel, advance, in_fire, out_fire, sel_q;
    logic              v_bal, v_inc, wr_valid_q;
    logic [DATA_W-1:0] a_raw, b_raw, a_bal, b_bal, picked, d_inc, wr_data_q;

    // global stall: output occupied and not taken
    assign advance     = !(wr_valid_q && !wr_ready);
    assign src_a_ready = issue_open && advance && src_b_valid;
    assign src_b_ready = issue_open && advance && src_a_valid;
    assign in_fire     = src_a_valid && src_a_ready;
    assign out_fire    = wr_valid_q && wr_ready;

    dpp_ctrl #(.ITER(ITER)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .in_fire(in_fire),
        .out_fire(out_fire), .issue_open(issue_open), .load_sel(load_sel),
        .busy(busy), .done(done), .wr_idx(wr_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        sel_q <= 1'b0;
        else if (load_sel) sel_q <= |sel_in;
    end

    dpp_delay_line #(.WIDTH(1), .DEPTH(LAT_MAX)) u_vld (
        .clk(clk), .rst_n(rst_n), .en(advance), .din(in_fire), .dout(v_bal));
    dpp_delay_line #(.WIDTH(DATA_W), .DEPTH(LAT_A)) u_path_a (
        .clk(clk), .rst_n(rst_n), .en(advance), .din(src_a_data), .dout(a_raw));
    dpp_delay_line #(.WIDTH(DATA_W), .DEPTH(LAT_B)) u_path_b (
        .clk(clk), .rst_n(rst_n), .en(advance), .din(src_b_data), .dout(b_raw));

    generate
        if (PAD_A > 0) begin : g_pad_a
            dpp_delay_line #(.WIDTH(DATA_W), .DEPTH(PAD_A)) u_pad (
                .clk(clk), .rst_n(rst_n), .en(advance), .din(a_raw), .dout(a_bal));
        end else begin : g_nopad_a
            assign a_bal = a_raw;
        end
        if (PAD_B > 0) begin : g_pad_b
            dpp_delay_line #(.WIDTH(DATA_W), .DEPTH(PAD_B)) u_pad (
                .clk(clk), .rst_n(rst_n), .en(advance), .din(b_raw), .dout(b_bal));
        end else begin : g_nopad_b
            assign b_bal = b_raw;
        end
    endgenerate

    assign picked = sel_q ? b_bal : a_bal;

    generate
        if (INC_LAT > 1) begin : g_inc_pipe
            logic [DATA_W:0] inc_out;
            dpp_delay_line #(.WIDTH(DATA_W + 1), .DEPTH(INC_LAT - 1)) u_inc (
                .clk(clk), .rst_n(rst_n), .en(advance),
                .din({v_bal, picked + DATA_W'(1)}), .dout(inc_out));
            assign v_inc = inc_out[DATA_W];
            assign d_inc = inc_out[DATA_W-1:0];
        end else begin : g_inc_flat
            assign v_inc = v_bal;
            assign d_inc = picked + DATA_W'(1);
        end
    endgenerate

    // write-port register, last stage of the increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid_q <= 1'b0;
            wr_data_q  <= '0;
        end else if (advance) begin
            wr_valid_q <= v_inc;
            wr_data_q  <= d_inc;
        end
    end

    assign wr_valid = wr_valid_q;
    assign wr_data  = wr_data_q;

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_idx))); // R8
    AST_JOIN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_valid && src_a_ready) |-> (src_b_valid && src_b_ready)); // R7
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_idx <= IW'(ITER - 1))); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_valid && wr_ready && (wr_idx == IW'(ITER - 1)))); // R9
    AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_ready || src_b_ready) |-> busy); // R5
endmodule

// File: tb/dpp_dual_path_test.sv
`timescale 1ns/1ps
module dpp_dual_path_test;
    localparam int N   = 20;
    localparam int LAT = 6;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0]  sel_in = '0;
    logic        src_a_valid = 1'b0, src_b_valid = 1'b0, wr_ready = 1'b0;
    logic [31:0] src_a_data = '0, src_b_data = '0;
    logic        src_a_ready, src_b_ready, wr_valid, done, busy;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data;

    int tests = 0, fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dpp_dual_path uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_in(sel_in),
        .src_a_valid(src_a_valid), .src_a_ready(src_a_ready), .src_a_data(src_a_data),
        .src_b_valid(src_b_valid), .src_b_ready(src_b_ready), .src_b_data(src_b_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data),
        .done(done), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] a_val(input int k);
        return (k == 19) ? 32'hFFFF_FFFF : 32'h1000_0000 + 32'(k) * 32'h0001_0003;
    endfunction
    function automatic logic [31:0] b_val(input int k);
        return (k == 18) ? 32'hFFFF_FFFF : 32'h2A00_0000 ^ (32'(k) * 32'h0101_0101);
    endfunction

    task automatic run_case(input logic [7:0] sel, input int mode);
        int acc = 0, wr = 0, cyc = 0;
        int acc_cyc [N];
        bit prev_stall = 0, prev_last = 0, seen_done = 0, ended = 0;
        logic [31:0] prev_d = '0, exp_d;
        logic [4:0]  prev_i = '0;
        @(negedge clk);
        start = 1'b1; sel_in = sel;
        src_a_valid = 1'b0; src_b_valid = 1'b0; wr_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        while (cyc < 3000 && !ended) begin
            @(negedge clk);
            sel_in = (cyc > 3) ? ~sel : sel;          // R2: ignored mid-run
            start  = (cyc == 10);                     // R10: ignored mid-run
            src_a_valid = (mode == 0) || (((cyc * 7 + 3) % 5) != 0);
            src_b_valid = (mode == 0) || ((cyc % 4) != 2);
            src_a_data  = a_val(acc < N ? acc : 0);
            src_b_data  = b_val(acc < N ? acc : 0);
            wr_ready    = (mode == 0) ? 1'b1 : (mode == 1) ? ((cyc % 3) != 1) : ((cyc % 4) < 2);
            #1;
            if (seen_done) begin
                chk(!busy && !done, "R9 busy/done low after pulse", {30'd0, busy, done}, 32'd0);
                ended = 1;
            end else begin
                if (done || prev_last) begin
                    chk(done == prev_last, "R9 done timing", 32'(done), 32'(prev_last));
                    if (done) seen_done = 1;
                end
                if (prev_stall)
                    chk(wr_valid && wr_data == prev_d && wr_idx == prev_i, "R8 hold under backpressure",
                        wr_data, prev_d);
                if (src_a_valid && !src_b_valid)
                    chk(!src_a_ready, "R7 a_ready without b_valid", 32'(src_a_ready), 32'd0);
                if (acc == N)
                    chk(!src_a_ready && !src_b_ready, "R5 readies closed after 20",
                        {30'd0, src_a_ready, src_b_ready}, 32'd0);
                if (src_a_valid && src_a_ready) begin
                    chk(src_b_valid && src_b_ready, "R7 joint handshake", 32'(src_b_ready), 32'd1);
                    acc_cyc[acc] = cyc;
                    acc++;
                end
                prev_last = 0;
                if (wr_valid && wr_ready) begin
                    exp_d = ((sel != 0) ? b_val(wr) : a_val(wr)) + 32'd1;
                    chk(wr_idx == 5'(wr), "R6 index order", 32'(wr_idx), 32'(wr));
                    chk(wr_data == exp_d, (sel != 0) ? "R3/R2 data sel=B" : "R3/R2 data sel=A", wr_data, exp_d);
                    if (mode == 0)
                        chk(cyc - acc_cyc[wr] == LAT, "R4 fixed latency", 32'(cyc - acc_cyc[wr]), 32'(LAT));
                    else
                        chk(cyc - acc_cyc[wr] >= LAT, "R4 minimum latency", 32'(cyc - acc_cyc[wr]), 32'(LAT));
                    wr++;
                    prev_last = (wr == N);
                end
                prev_stall = wr_valid && !wr_ready;
                prev_d = wr_data; prev_i = wr_idx;
            end
            cyc++;
        end
        start = 1'b0;
        chk(acc == N && wr == N, "R5 item count", 32'(wr), 32'(N));
        chk(seen_done, "R9 done seen", 32'(seen_done), 32'd1);
        if (!ended) chk(1'b0, "run watchdog", 32'(cyc), 32'd3000);
    endtask

    initial begin
        logic [7:0] sels [4];
        sels[0] = 8'h00; sels[1] = 8'h01; sels[2] = 8'h80; sels[3] = 8'hFF;
        repeat (3) @(negedge clk);
        #1;
        chk(!wr_valid && !done && !busy && !src_a_ready && !src_b_ready, "R1 in reset",
            {27'd0, wr_valid, done, busy, src_a_ready, src_b_ready}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!wr_valid && !done && !busy && !src_a_ready && !src_b_ready, "R1 after reset",
            {27'd0, wr_valid, done, busy, src_a_ready, src_b_ready}, 32'd0);
        for (int s = 0; s < 4; s++)
            for (int m = 0; m < 3; m++)
                run_case(sels[s], m);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule